// File: doc/BRIEF.md
# Three-Channel Interleaved Timer Register File

This block is the register front end for a group of three timer channels. A single 32-bit word bus reaches all of them. Registers of the same kind sit in groups of three consecutive words, one word per channel. The channel is the word index modulo 3, and the register kind is the word index divided by 3. The block holds the configuration registers for every channel: clock control, counter control, interval, three match values, interrupt enable and event control. It drives them continuously to the channel logic.

The channel logic itself is outside this block. It supplies its live count, its event count and its interrupt status as inputs. The block returns these through the bus, zero-extended to 32 bits. It does not store them. Reading a channel's status register raises a one-cycle clear strobe toward that channel, so the status clears in the same access that reads it. Writing counter control with bit 4 set raises a one-cycle count-reset strobe toward the addressed channel.

Every access takes one cycle. Writes take effect at the clock edge that ends the request cycle. Read data is registered at that same edge and holds until the next read.

Top module: `tri_timer_regs`

## Requirements
- R1: The word index is the byte address shifted right by 2, so address bits 1:0 are ignored. The channel is the word index modulo 3. The register kind is the word index divided by 3, in this order: 0 clock control, 1 counter control, 2 count value, 3 interval, 4 match 1, 5 match 2, 6 match 3, 7 interrupt status, 8 interrupt enable, 9 event control, 10 event count.
- R2: After reset, counter control reads 0x21 on every channel. Every other stored register reads 0, and read data is 0.
- R3: Clock control, counter control and interrupt enable keep write-data bits 5:0. Event control keeps bits 2:0. Interval and the match registers keep bits 15:0. Stored values read back zero-extended.
- R4: A counter control write with data bit 4 set pulses that channel's bit of `cnt_rst_o` during the request cycle. Bit 4 is never stored and always reads back 0.
- R5: A read of interrupt status returns that channel's `status_i` slice, zero-extended. During the request cycle it pulses the channel's bit of `stat_clr_o`.
- R6: Writes to the count value, interrupt status and event count registers change no stored register and raise no strobe.
- R7: A read of count value or event count returns the addressed channel's 16-bit input, zero-extended.
- R8: Word indices of 33 and above are unmapped. A read there returns 0, and a write there has no effect.
- R9: `bus_rdata` changes only at the edge that ends a read request cycle. Between reads it holds its value, whatever writes or idle cycles occur.
- R10: At most one bit of `stat_clr_o` and of `cnt_rst_o` is ever set. The strobes are high only during a matching request.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Active-low synchronous reset |
| bus_valid | input | 1 | Access request this cycle |
| bus_write | input | 1 | 1 = write, 0 = read |
| bus_addr | input | ADDR_W | Byte address |
| bus_wdata | input | 32 | Write data |
| bus_rdata | output | 32 | Read data, registered |
| clk_ctrl_o | output | 18 | Clock control, 6 bits per channel |
| cnt_ctrl_o | output | 18 | Counter control, 6 bits per channel |
| interval_o | output | 48 | Interval, 16 bits per channel |
| match_o | output | 144 | Match values, slot (channel*3+k) |
| irq_en_o | output | 18 | Interrupt enable, 6 bits per channel |
| evt_ctrl_o | output | 9 | Event control, 3 bits per channel |
| cnt_rst_o | output | 3 | Count-reset strobe per channel |
| stat_clr_o | output | 3 | Status-clear strobe per channel |
| count_i | input | 48 | Live count per channel |
| evt_cnt_i | input | 48 | Event count per channel |
| status_i | input | 18 | Interrupt status per channel |

## Verification
A wrong decode of the channel or the register kind has two visible effects. A write lands in the wrong channel's output bundle, which shows on the next clock. A read returns a neighbour's value one cycle after the request. A missing or misplaced strobe shows during the request cycle itself. A missed status clear also shows one cycle after the next read of that status, because the bench's channel model drops its status only on the strobe. Faulty storage masks or a stored reset bit show on the register outputs at the clock after the write.

// File: rtl/tri_timer_regs.sv
module tri_timer_regs #(
  parameter int ADDR_W = 12,
  parameter int CTRL_W = 6,
  parameter int EVC_W  = 3,
  parameter int VAL_W  = 16,
  parameter int DATA_W = 32,
  parameter logic [CTRL_W-1:0] CNT_CTRL_INIT = 6'h21
) (
  input  logic                    clk,
  input  logic                    rst_n,
  input  logic                    bus_valid,
  input  logic                    bus_write,
  input  logic [ADDR_W-1:0]       bus_addr,
  input  logic [DATA_W-1:0]       bus_wdata,
  output logic [DATA_W-1:0]       bus_rdata,
  output logic [3*CTRL_W-1:0]     clk_ctrl_o,
  output logic [3*CTRL_W-1:0]     cnt_ctrl_o,
  output logic [3*VAL_W-1:0]      interval_o,
  output logic [9*VAL_W-1:0]      match_o,
  output logic [3*CTRL_W-1:0]     irq_en_o,
  output logic [3*EVC_W-1:0]      evt_ctrl_o,
  output logic [2:0]              cnt_rst_o,
  output logic [2:0]              stat_clr_o,
  input  logic [3*VAL_W-1:0]      count_i,
  input  logic [3*VAL_W-1:0]      evt_cnt_i,
  input  logic [3*CTRL_W-1:0]     status_i
);
  localparam int NCH    = 3;
  localparam int NMATCH = 3;
  localparam int NTYPE  = 11;
  localparam int NWORDS = NTYPE * NCH;
  localparam int WIDX_W = ADDR_W - 2;
  localparam int RST_BIT = 4;
  localparam logic [CTRL_W-1:0] CNT_KEEP = ~(CTRL_W'(1) << RST_BIT);

  localparam logic [3:0] T_CLK = 4'd0, T_CNT = 4'd1, T_VAL = 4'd2, T_IVL = 4'd3,
                         T_M1 = 4'd4, T_STAT = 4'd7, T_IEN = 4'd8,
                         T_EVC = 4'd9, T_EVN = 4'd10;

  logic [WIDX_W-1:0] widx;
  logic              mapped, rd, wr;
  logic [3:0]        rtype;
  logic [1:0]        chan;
  logic [2:0]        chan_sel;
  logic [DATA_W-1:0] rd_val;

  logic [CTRL_W-1:0] clk_q [NCH];
  logic [CTRL_W-1:0] cnt_q [NCH];
  logic [CTRL_W-1:0] ien_q [NCH];
  logic [EVC_W-1:0]  evc_q [NCH];
  logic [VAL_W-1:0]  ivl_q [NCH];
  logic [VAL_W-1:0]  mat_q [NCH][NMATCH];

  assign widx     = bus_addr[ADDR_W-1:2];
  assign mapped   = widx < WIDX_W'(NWORDS);
  assign rtype    = 4'(widx / WIDX_W'(NCH));
  assign chan     = 2'(widx % WIDX_W'(NCH));
  assign chan_sel = mapped ? (3'b001 << chan) : 3'b000;
  assign rd       = bus_valid & ~bus_write;
  assign wr       = bus_valid & bus_write;

  assign stat_clr_o = (rd && rtype == T_STAT) ? chan_sel : 3'b000;
  assign cnt_rst_o  = (wr && rtype == T_CNT && bus_wdata[RST_BIT]) ? chan_sel : 3'b000;

  always_ff @(posedge clk) begin
    if (!rst_n) begin
      for (int c = 0; c < NCH; c++) begin
        clk_q[c] <= '0;
        cnt_q[c] <= CNT_CTRL_INIT;
        ien_q[c] <= '0;
        evc_q[c] <= '0;
        ivl_q[c] <= '0;
        for (int k = 0; k < NMATCH; k++) mat_q[c][k] <= '0;
      end
    end else if (wr) begin
      for (int c = 0; c < NCH; c++) begin
        if (chan_sel[c]) begin
          case (rtype)
            T_CLK: clk_q[c] <= bus_wdata[CTRL_W-1:0];
            T_CNT: cnt_q[c] <= bus_wdata[CTRL_W-1:0] & CNT_KEEP;
            T_IVL: ivl_q[c] <= bus_wdata[VAL_W-1:0];
            T_IEN: ien_q[c] <= bus_wdata[CTRL_W-1:0];
            T_EVC: evc_q[c] <= bus_wdata[EVC_W-1:0];
            default: ;
          endcase
          for (int k = 0; k < NMATCH; k++)
            if (rtype == T_M1 + 4'(k)) mat_q[c][k] <= bus_wdata[VAL_W-1:0];
        end
      end
    end
  end

  always_comb begin
    rd_val = '0;
    if (mapped) begin
      case (rtype)
        T_CLK:  rd_val = DATA_W'(clk_q[chan]);
        T_CNT:  rd_val = DATA_W'(cnt_q[chan]);
        T_VAL:  rd_val = DATA_W'(count_i[chan*VAL_W +: VAL_W]);
        T_IVL:  rd_val = DATA_W'(ivl_q[chan]);
        T_STAT: rd_val = DATA_W'(status_i[chan*CTRL_W +: CTRL_W]);
        T_IEN:  rd_val = DATA_W'(ien_q[chan]);
        T_EVC:  rd_val = DATA_W'(evc_q[chan]);
        T_EVN:  rd_val = DATA_W'(evt_cnt_i[chan*VAL_W +: VAL_W]);
        default:
          for (int k = 0; k < NMATCH; k++)
            if (rtype == T_M1 + 4'(k)) rd_val = DATA_W'(mat_q[chan][k]);
      endcase
    end
  end

  always_ff @(posedge clk) begin
    if (!rst_n)  bus_rdata <= '0;
    else if (rd) bus_rdata <= rd_val;
  end

  for (genvar c = 0; c < NCH; c++) begin : g_out
    assign clk_ctrl_o[c*CTRL_W +: CTRL_W] = clk_q[c];
    assign cnt_ctrl_o[c*CTRL_W +: CTRL_W] = cnt_q[c];
    assign irq_en_o[c*CTRL_W +: CTRL_W]   = ien_q[c];
    assign evt_ctrl_o[c*EVC_W +: EVC_W]   = evc_q[c];
    assign interval_o[c*VAL_W +: VAL_W]   = ivl_q[c];
    for (genvar k = 0; k < NMATCH; k++) begin : g_m
      assign match_o[(c*NMATCH+k)*VAL_W +: VAL_W] = mat_q[c][k];
    end
  end

  logic writable;
  assign writable = wr && mapped && rtype != T_VAL && rtype != T_STAT &&
                    rtype != T_EVN;

  // R10
  strobe_onehot_chk: assert property (@(posedge clk) disable iff (!rst_n)
    $onehot0(stat_clr_o) && $onehot0(cnt_rst_o));
  // R5
  clr_on_read_chk: assert property (@(posedge clk) disable iff (!rst_n)
    (|stat_clr_o) |-> (bus_valid && !bus_write));
  // R4
  rst_on_write_chk: assert property (@(posedge clk) disable iff (!rst_n)
    (|cnt_rst_o) |-> (bus_valid && bus_write && bus_wdata[RST_BIT]));
  // R4
  rst_bit_clear_chk: assert property (@(posedge clk) disable iff (!rst_n)
    (cnt_ctrl_o & {NCH{~CNT_KEEP}}) == '0);
  // R9
  rdata_hold_chk: assert property (@(posedge clk) disable iff (!rst_n)
    !rd |=> $stable(bus_rdata));
  // R6
  ignored_write_chk: assert property (@(posedge clk) disable iff (!rst_n)
    (wr && !writable) |=> $stable({clk_ctrl_o, cnt_ctrl_o, interval_o, match_o,
                                   irq_en_o, evt_ctrl_o}));
endmodule

// File: tb/tri_timer_regs_bench.sv
module tri_timer_regs_bench;
  logic         clk = 1'b0;
  logic         rst_n = 1'b0;
  logic         bus_valid = 1'b0, bus_write = 1'b0;
  logic [11:0]  bus_addr = '0;
  logic [31:0]  bus_wdata = '0;
  logic [31:0]  bus_rdata;
  logic [17:0]  clk_ctrl_o, cnt_ctrl_o, irq_en_o;
  logic [47:0]  interval_o;
  logic [143:0] match_o;
  logic [8:0]   evt_ctrl_o;
  logic [2:0]   cnt_rst_o, stat_clr_o;
  logic [47:0]  count_i, evt_cnt_i;
  logic [17:0]  status_i;

  int st [3];
  int cv [3];
  int ev [3];
  int m_clk [3], m_cnt [3], m_ien [3], m_evc [3], m_ivl [3];
  int m_mat [3][3];
  int m_rd;
  int checks = 0, fails = 0;
  bit done = 0;

  always #4 clk = ~clk;

  always_comb
    for (int c = 0; c < 3; c++) begin
      status_i[c*6 +: 6]   = 6'(st[c]);
      count_i[c*16 +: 16]  = 16'(cv[c]);
      evt_cnt_i[c*16 +: 16] = 16'(ev[c]);
    end

  tri_timer_regs u_tri_timer_regs (
    .clk(clk), .rst_n(rst_n), .bus_valid(bus_valid), .bus_write(bus_write),
    .bus_addr(bus_addr), .bus_wdata(bus_wdata), .bus_rdata(bus_rdata),
    .clk_ctrl_o(clk_ctrl_o), .cnt_ctrl_o(cnt_ctrl_o), .interval_o(interval_o),
    .match_o(match_o), .irq_en_o(irq_en_o), .evt_ctrl_o(evt_ctrl_o),
    .cnt_rst_o(cnt_rst_o), .stat_clr_o(stat_clr_o), .count_i(count_i),
    .evt_cnt_i(evt_cnt_i), .status_i(status_i));

  task automatic chk(input logic [159:0] act, input logic [159:0] exp,
                     input string tag, input string what);
    checks++;
    if (act !== exp) begin
      fails++;
      $display("FAIL %s %s actual=%0h expected=%0h", tag, what, act, exp);
    end
  endtask

  function automatic int model_read(input int t, input int c);
    case (t)
      0: return m_clk[c];
      1: return m_cnt[c];
      2: return cv[c];
      3: return m_ivl[c];
      4, 5, 6: return m_mat[c][t-4];
      7: return st[c];
      8: return m_ien[c];
      9: return m_evc[c];
      default: return ev[c];
    endcase
  endfunction

  task automatic compare_all(input string tag);
    logic [17:0] e_clk, e_cnt, e_ien;
    logic [47:0] e_ivl;
    logic [143:0] e_mat;
    logic [8:0] e_evc;
    for (int c = 0; c < 3; c++) begin
      e_clk[c*6 +: 6] = 6'(m_clk[c]);
      e_cnt[c*6 +: 6] = 6'(m_cnt[c]);
      e_ien[c*6 +: 6] = 6'(m_ien[c]);
      e_evc[c*3 +: 3] = 3'(m_evc[c]);
      e_ivl[c*16 +: 16] = 16'(m_ivl[c]);
      for (int k = 0; k < 3; k++) e_mat[(c*3+k)*16 +: 16] = 16'(m_mat[c][k]);
    end
    chk(160'(bus_rdata), 160'(32'(m_rd)), tag, "rdata");
    chk(160'(clk_ctrl_o), 160'(e_clk), tag, "clk_ctrl");
    chk(160'(cnt_ctrl_o), 160'(e_cnt), tag, "cnt_ctrl");
    chk(160'(irq_en_o), 160'(e_ien), tag, "irq_en");
    chk(160'(evt_ctrl_o), 160'(e_evc), tag, "evt_ctrl");
    chk(160'(interval_o), 160'(e_ivl), tag, "interval");
    chk(160'(match_o), 160'(e_mat), tag, "match");
  endtask

  task automatic cyc(input bit v, input bit w, input int a, input int d,
                     input string tag);
    int widx = (a & 12'hFFF) >> 2;
    bit mp = widx < 33;
    int t = widx / 3;
    int c = widx % 3;
    logic [2:0] e_clr = '0, e_rst = '0;
    bus_valid = v; bus_write = w; bus_addr = 12'(a); bus_wdata = d;
    #1;
    if (v && !w && mp && t == 7) e_clr[c] = 1'b1;
    if (v && w && mp && t == 1 && d[4]) e_rst[c] = 1'b1;
    chk(160'(stat_clr_o), 160'(e_clr), tag, "stat_clr");
    chk(160'(cnt_rst_o), 160'(e_rst), tag, "cnt_rst");
    if (v && !w) m_rd = mp ? model_read(t, c) : 0;
    if (v && w && mp)
      case (t)
        0: m_clk[c] = d & 'h3F;
        1: m_cnt[c] = d & 'h2F;
        3: m_ivl[c] = d & 'hFFFF;
        4, 5, 6: m_mat[c][t-4] = d & 'hFFFF;
        8: m_ien[c] = d & 'h3F;
        9: m_evc[c] = d & 'h7;
        default: ;
      endcase
    @(posedge clk);
    #1;
    if (e_clr != 0) st[c] = 0;
    @(negedge clk);
    compare_all(tag);
  endtask

  initial begin
    #1_000_000;
    if (!done) begin
      checks++; fails++;
      $display("FAIL watchdog expired");
      $display("  *** SUMMARY: %0d compared / %0d mismatched ***", checks, fails);
      $finish;
    end
  end

  initial begin
    for (int c = 0; c < 3; c++) begin
      st[c] = 0; cv[c] = 0; ev[c] = 0;
      m_clk[c] = 0; m_cnt[c] = 'h21; m_ien[c] = 0; m_evc[c] = 0; m_ivl[c] = 0;
      for (int k = 0; k < 3; k++) m_mat[c][k] = 0;
    end
    m_rd = 0;
    repeat (3) @(posedge clk);
    #1 rst_n = 1'b1;
    @(negedge clk);
    // R2 reset values
    compare_all("R2");
    for (int c = 0; c < 3; c++) cyc(1, 0, 'h0C + 4*c, 0, "R2");

    // R3 masks on every writable kind, each channel distinct
    for (int c = 0; c < 3; c++) begin
      cyc(1, 1, 'h00 + 4*c, 'hFFFF_FFC0 | (c + 5), "R3");
      cyc(1, 1, 'h0C + 4*c, 'hFFFF_FF00 | (c + 1), "R3");
      cyc(1, 1, 'h24 + 4*c, 'h1234_0000 | (c * 'h1111 + 'h0101), "R3");
      for (int k = 0; k < 3; k++)
        cyc(1, 1, 'h30 + 12*k + 4*c, 'hABCD_0000 | ((k+1)*'h1000 + c), "R3");
      cyc(1, 1, 'h60 + 4*c, 'h7FFF_FFFF - c, "R3");
      cyc(1, 1, 'h6C + 4*c, 'hF8 | (c + 2), "R3");
    end

    // R1 read every mapped word, plus byte-lane bits ignored
    for (int c = 0; c < 3; c++) cv[c] = 'h1000 * (c + 1) + 'h0A;
    for (int w = 0; w < 33; w++) cyc(1, 0, w * 4, 0, "R1");
    cyc(1, 0, 'h26, 0, "R1");
    cyc(1, 0, 'h4B, 0, "R1");

    // R4 counter reset strobe, bit not stored
    cyc(1, 1, 'h10, 'h3F, "R4");
    cyc(1, 0, 'h10, 0, "R4");
    cyc(1, 1, 'h14, 'h10, "R4");
    cyc(1, 0, 'h14, 0, "R4");

    // R5 clear-on-read
    st[0] = 'h15; st[1] = 'h2A; st[2] = 'h3F;
    cyc(1, 0, 'h58, 0, "R5");
    cyc(1, 0, 'h58, 0, "R5");
    cyc(1, 0, 'h54, 0, "R5");
    cyc(1, 0, 'h5C, 0, "R5");
    cyc(1, 0, 'h5C, 0, "R5");

    // R6 writes to read-only kinds ignored
    st[1] = 'h0F;
    cyc(1, 1, 'h18, -1, "R6");
    cyc(1, 1, 'h58, -1, "R6");
    cyc(1, 1, 'h7C, -1, "R6");
    cyc(1, 0, 'h58, 0, "R6");

    // R7 live inputs zero-extended
    cv[0] = 'hBEEF; cv[1] = 'hFFFF; cv[2] = 'h8001;
    ev[0] = 'h0042; ev[1] = 'hC0DE; ev[2] = 'hFFFE;
    for (int c = 0; c < 3; c++) begin
      cyc(1, 0, 'h18 + 4*c, 0, "R7");
      cyc(1, 0, 'h78 + 4*c, 0, "R7");
    end

    // R8 unmapped words
    cyc(1, 0, 'h24, 0, "R8");
    cyc(1, 0, 'h84, 0, "R8");
    cyc(1, 0, 'h30, 0, "R8");
    cyc(1, 0, 'hFFC, 0, "R8");
    cyc(1, 1, 'h84, -1, "R8");
    cyc(1, 1, 'h100, -1, "R8");
    cyc(1, 1, 'hFFC, -1, "R8");

    // R9 hold between reads
    cyc(1, 0, 'h24, 0, "R9");
    cyc(0, 0, 'h84, 0, "R9");
    cyc(1, 1, 'h28, 'h5555, "R9");
    cyc(0, 1, 'h00, 'h3F, "R9");
    cyc(1, 1, 'hFFC, 0, "R9");
    cyc(1, 0, 'h28, 0, "R9");

    // R10 strobes absent when idle with decodable address
    cyc(0, 0, 'h54, 0, "R10");
    cyc(0, 1, 'h0C, 'h10, "R10");

    done = 1;
    $display("  *** SUMMARY: %0d compared / %0d mismatched ***", checks, fails);
    $finish;
  end
endmodule